// File: doc/BRIEF.md
# Serial port status flag register

This block is the 8-bit status register of an asynchronous serial port. It collects the transmit and receive handshake flags and the receive error flags. The transmit and receive datapaths raise these flags through single-cycle event strobes, and software reads the register over a simple bus port. Software acknowledges a flag in two steps. It first reads the register while the flag is set, then writes 0 to that bit position. A write of 1, or a write of 0 with no prior qualifying read, leaves the flag alone.

On receive, the block decides how each completed frame is handled. A frame that arrives while the previous byte is still unread is reported as an overrun. A frame with a bad stop bit or a parity mismatch is reported as an error. Only a clean frame is accepted: the block pulses a load strobe so that the receive datapath moves the byte into its data register. The block also stores the multiprocessor bit of the last accepted frame. It holds a software-owned multiprocessor bit that the transmitter sends with outgoing frames. A standby input returns every bit to its reset value.

Top module: `sio_status_reg`

## Requirements
- R1: `rdata_o` has this bit layout: bit 7 transmit-empty, bit 6 receive-full, bit 5 overrun, bit 4 framing error, bit 3 parity error, bit 2 transmit-done, bit 1 received multiprocessor bit, bit 0 transmit multiprocessor bit.
- R2: After reset is released, and in the cycle after `standby_i` is high, the register reads 8'h84. Only transmit-empty and transmit-done are 1.
- R3: Bits 7..3 fall only through software. They change only when a write carries 0 in that bit position and the flag is armed. Writing 1 to them has no effect.
- R4: Each of bits 7..3 has its own arm. A read (`rd_i`) that sees the flag at 1 arms it. The next write disarms it, whether or not that write clears anything. A read that sees the flag at 0 does not arm it.
- R5: Transmit-empty is set while `tx_en_i` is 0 and on a `tx_load_i` strobe.
- R6: Transmit-done is set while `tx_en_i` is 0, and on `tx_last_i` when transmit-empty is 1. It falls only when transmit-empty is cleared by software. Writes to bit 2 are ignored.
- R7: A frame is clean when `rx_done_i` is high, receive-full is 0, the stop bit is 1 and parity matches. A clean frame sets receive-full, pulses `rx_load_o` in the same cycle, and captures `rx_mpb_i` into bit 1. Bit 1 changes on no other occasion except reset or standby.
- R8: A frame that completes while receive-full is 1 sets only the overrun flag. `rx_load_o` stays low, and receive-full and bit 1 keep their values.
- R9: A completed frame with `rx_stop_i`=0, when no overrun applies, sets the framing error flag and is not loaded.
- R10: With `par_en_i`=1, the parity check uses `rx_xor_i ^ rx_par_i`. This value must be 0 when `par_odd_i`=0 and 1 when `par_odd_i`=1. A mismatch, when no overrun applies, sets the parity error flag and the frame is not loaded.
- R11: A hardware set in the same cycle as a qualifying clearing write leaves the flag set.
- R12: Bit 0 is written freely from `wdata_i[0]` on every write and drives `tx_mpb_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Forces every bit to its reset value |
| rd_i | input | 1 | Bus read strobe; arms the flags that currently read 1 |
| wr_i | input | 1 | Bus write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register contents |
| tx_en_i | input | 1 | Transmitter enable |
| tx_load_i | input | 1 | Transmit byte moved into the shifter |
| tx_last_i | input | 1 | Last bit of a character sent |
| rx_done_i | input | 1 | Receive frame completed |
| rx_stop_i | input | 1 | Sampled stop bit |
| par_en_i | input | 1 | Parity checking enabled |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rx_xor_i | input | 1 | XOR of the received data bits |
| rx_par_i | input | 1 | Received parity bit |
| rx_mpb_i | input | 1 | Received multiprocessor bit |
| rx_load_o | output | 1 | Move the received byte into the receive data register |
| tx_mpb_o | output | 1 | Multiprocessor bit for outgoing frames |

## Verification
The assertions check properties that hold on every cycle:
- flags 7..3 never fall without a write or standby;
- transmit-done falls only together with transmit-empty;
- a disabled transmitter or a `tx_load_i` strobe always leaves transmit-empty set, even against a clear;
- a frame that completes on a full receiver yields overrun and no load;
- bit 1 holds whenever no frame is loaded.

Other behaviour depends on sequences of events, and only the bench scenarios show it:
- a clear needs a prior read that saw the flag set;
- an intervening write consumes the arm;
- a read of a 0 flag does not arm it;
- each error type follows its own stimulus, and the odd/even parity polarity is checked against the inputs.

// File: rtl/sio_status_pkg.sv
package sio_status_pkg;
  localparam int unsigned SR_W   = 8;
  localparam int unsigned NUM_SW = 5;       // software-cleared flags, bits 7..3
  localparam int unsigned SW_LSB = SR_W - NUM_SW;
  localparam int unsigned B_TXE  = 7;
  localparam int unsigned B_TXDN = 2;
  localparam int unsigned B_MPRX = 1;
  localparam int unsigned B_MPTX = 0;

  typedef struct packed {
    logic rxf;
    logic ovr;
    logic ferr;
    logic perr;
    logic load;
  } rx_evt_t;
endpackage

// File: rtl/sio_flag_cell.sv
module sio_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic set_i,
  output logic q_o,
  output logic clr_o
);
  logic q_q, arm_q;
  logic clr_req;

  assign clr_req = wr_i && !wbit_i && arm_q;
  assign clr_o   = clr_req && !set_i && !standby_i;
  assign q_o     = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= RST_VAL;
      arm_q <= 1'b0;
    end else if (standby_i) begin
      q_q   <= RST_VAL;
      arm_q <= 1'b0;
    end else begin
      // set beats clear
      if (set_i)        q_q <= 1'b1;
      else if (clr_req) q_q <= 1'b0;
      if (rd_i && q_q)  arm_q <= 1'b1;
      else if (wr_i)    arm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_rx_eval.sv
module sio_rx_eval
  import sio_status_pkg::*;
(
  input  logic    rx_done_i,
  input  logic    rxf_i,
  input  logic    rx_stop_i,
  input  logic    par_en_i,
  input  logic    par_odd_i,
  input  logic    rx_xor_i,
  input  logic    rx_par_i,
  output rx_evt_t evt_o
);
  logic accept, par_bad;

  assign par_bad = par_en_i && ((rx_xor_i ^ rx_par_i) != par_odd_i);
  assign accept  = rx_done_i && !rxf_i;

  always_comb begin
    evt_o      = '0;
    evt_o.ovr  = rx_done_i && rxf_i;
    evt_o.ferr = accept && !rx_stop_i;
    evt_o.perr = accept && par_bad;
    evt_o.load = accept && rx_stop_i && !par_bad;
    evt_o.rxf  = evt_o.load;
  end
endmodule

// File: rtl/sio_tx_eval.sv
module sio_tx_eval (
  input  logic tx_en_i,
  input  logic tx_load_i,
  input  logic tx_last_i,
  input  logic txe_i,
  output logic txe_set_o,
  output logic txdn_set_o
);
  assign txe_set_o  = !tx_en_i || tx_load_i;
  assign txdn_set_o = !tx_en_i || (tx_last_i && txe_i);
endmodule

// File: rtl/sio_status_reg.sv
module sio_status_reg
  import sio_status_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            standby_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [SR_W-1:0] wdata_i,
  output logic [SR_W-1:0] rdata_o,
  input  logic            tx_en_i,
  input  logic            tx_load_i,
  input  logic            tx_last_i,
  input  logic            rx_done_i,
  input  logic            rx_stop_i,
  input  logic            par_en_i,
  input  logic            par_odd_i,
  input  logic            rx_xor_i,
  input  logic            rx_par_i,
  input  logic            rx_mpb_i,
  output logic            rx_load_o,
  output logic            tx_mpb_o
);
  localparam int unsigned TXE_IDX = B_TXE - SW_LSB;

  logic [NUM_SW-1:0] sw_set, sw_clr, sw_q;
  rx_evt_t           rx_evt;
  logic              txe_set, txdn_set;
  logic              txdn_q, mprx_q, mptx_q;

  sio_rx_eval u_rx (
    .rx_done_i (rx_done_i),
    .rxf_i     (sw_q[B_TXE-1-SW_LSB]),
    .rx_stop_i (rx_stop_i),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .rx_xor_i  (rx_xor_i),
    .rx_par_i  (rx_par_i),
    .evt_o     (rx_evt)
  );

  sio_tx_eval u_tx (
    .tx_en_i    (tx_en_i),
    .tx_load_i  (tx_load_i),
    .tx_last_i  (tx_last_i),
    .txe_i      (sw_q[TXE_IDX]),
    .txe_set_o  (txe_set),
    .txdn_set_o (txdn_set)
  );

  // index i maps to register bit SW_LSB+i
  assign sw_set = {txe_set, rx_evt.rxf, rx_evt.ovr, rx_evt.ferr, rx_evt.perr};

  for (genvar i = 0; i < NUM_SW; i++) begin : g_flag
    sio_flag_cell #(
      .RST_VAL ((i == TXE_IDX) ? 1'b1 : 1'b0)
    ) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .standby_i (standby_i),
      .rd_i      (rd_i),
      .wr_i      (wr_i),
      .wbit_i    (wdata_i[SW_LSB+i]),
      .set_i     (sw_set[i]),
      .q_o       (sw_q[i]),
      .clr_o     (sw_clr[i])
    );
  end

  // transmit-done follows the transmit-empty clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 txdn_q <= 1'b1;
    else if (standby_i)          txdn_q <= 1'b1;
    else if (txdn_set)           txdn_q <= 1'b1;
    else if (sw_clr[TXE_IDX])    txdn_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mprx_q <= 1'b0;
      mptx_q <= 1'b0;
    end else if (standby_i) begin
      mprx_q <= 1'b0;
      mptx_q <= 1'b0;
    end else begin
      if (rx_evt.load) mprx_q <= rx_mpb_i;
      if (wr_i)        mptx_q <= wdata_i[B_MPTX];
    end
  end

  always_comb begin
    rdata_o                     = '0;
    rdata_o[SR_W-1:SW_LSB]      = sw_q;
    rdata_o[B_TXDN]             = txdn_q;
    rdata_o[B_MPRX]             = mprx_q;
    rdata_o[B_MPTX]             = mptx_q;
  end

  assign rx_load_o = rx_evt.load && !standby_i;
  assign tx_mpb_o  = mptx_q;
endmodule

// File: rtl/sio_status_chk.sv
module sio_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       standby_i,
  input logic       wr_i,
  input logic       tx_en_i,
  input logic       tx_load_i,
  input logic       rx_done_i,
  input logic       rx_load_o,
  input logic [7:0] rdata_o
);
  p_txe_sw_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdata_o[7]) |-> ($past(wr_i) || $past(standby_i)));
  p_rxf_sw_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdata_o[6]) |-> ($past(wr_i) || $past(standby_i)));
  p_ovr_sw_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdata_o[5]) |-> ($past(wr_i) || $past(standby_i)));
  p_err_sw_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rdata_o[4]) || $fell(rdata_o[3])) |-> ($past(wr_i) || $past(standby_i)));
  p_txe_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !standby_i) |=> rdata_o[7]);
  p_txdn_with_txe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdata_o[2]) |-> $fell(rdata_o[7]));
  p_mpb_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_load_o && !standby_i) |=> $stable(rdata_o[1]));
  p_ovr_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rdata_o[6] && !standby_i) |=> rdata_o[5]);
  p_ovr_noload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rdata_o[6]) |-> !rx_load_o);
  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_i && !standby_i) |=> rdata_o[7]);
endmodule

bind sio_status_reg sio_status_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .standby_i (standby_i),
  .wr_i      (wr_i),
  .tx_en_i   (tx_en_i),
  .tx_load_i (tx_load_i),
  .rx_done_i (rx_done_i),
  .rx_load_o (rx_load_o),
  .rdata_o   (rdata_o)
);

// File: tb/sio_status_reg_tb.sv
module sio_status_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic standby = 0, rd = 0, wr = 0;
  logic [7:0] wdata = 0;
  logic tx_en = 1, tx_load = 0, tx_last = 0;
  logic rx_done = 0, rx_stop = 1, par_en = 0, par_odd = 0, rx_xor = 0, rx_par = 0, rx_mpb = 0;
  logic [7:0] rdata;
  logic rx_load, tx_mpb;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_status_reg u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .standby_i(standby), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_en_i(tx_en), .tx_load_i(tx_load),
    .tx_last_i(tx_last), .rx_done_i(rx_done), .rx_stop_i(rx_stop),
    .par_en_i(par_en), .par_odd_i(par_odd), .rx_xor_i(rx_xor), .rx_par_i(rx_par),
    .rx_mpb_i(rx_mpb), .rx_load_o(rx_load), .tx_mpb_o(tx_mpb)
  );

  // monitor: compares register contents against queued expectations
  always begin
    wait (exp_q.size() != 0);
    begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e || tx_mpb !== e[0]) begin
        n_fail++;
        $display("FAIL %s: rdata=%h tx_mpb=%b expected %h", t, rdata, tx_mpb, e);
      end
    end
  end

  // driver: inputs are set at a negedge, then one clock is applied
  task automatic tick(input logic [7:0] exp, input logic exp_load, input string tag);
    #1;
    n_chk++;
    if (rx_load !== exp_load) begin
      n_fail++;
      $display("FAIL %s: rx_load=%b expected %b", tag, rx_load, exp_load);
    end
    @(posedge clk);
    #1;
    rd = 0; wr = 0; tx_load = 0; tx_last = 0; rx_done = 0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic do_wr(input logic [7:0] d, input logic [7:0] exp, input string tag);
    wr = 1; wdata = d;
    tick(exp, 1'b0, tag);
  endtask

  task automatic do_rd(input logic [7:0] exp, input string tag);
    rd = 1;
    tick(exp, 1'b0, tag);
  endtask

  task automatic frame(input logic stop, input logic pe, input logic odd, input logic x,
                       input logic p, input logic m, input logic [7:0] exp,
                       input logic ld, input string tag);
    rx_done = 1; rx_stop = stop; par_en = pe; par_odd = odd; rx_xor = x; rx_par = p; rx_mpb = m;
    tick(exp, ld, tag);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_ni = 1;
        @(negedge clk);
        tick(8'h84, 1'b0, "R2 reset value R1 layout");
        do_wr(8'h00, 8'h84, "R3 write 0 without read");
        do_wr(8'hFF, 8'h85, "R3 R12 write 1 ignored, bit0 written");
        do_rd(8'h85, "R4 read arms");
        do_wr(8'h01, 8'h01, "R3 R6 clear txe clears transmit-done");
        tx_last = 1; tick(8'h01, 1'b0, "R6 last bit with txe low");
        tx_load = 1; tick(8'h81, 1'b0, "R5 load sets txe");
        tx_last = 1; tick(8'h85, 1'b0, "R6 last bit with txe high");
        do_rd(8'h85, "R4 read arms");
        do_wr(8'h01, 8'h01, "R3 clear txe again");
        tx_en = 0; tick(8'h85, 1'b0, "R5 R6 tx disabled");
        tx_en = 1;
        frame(1, 0, 0, 0, 0, 1, 8'hC7, 1'b1, "R7 clean frame");
        frame(0, 0, 0, 0, 0, 0, 8'hE7, 1'b0, "R8 overrun only");
        do_rd(8'hE7, "R4 read arms");
        do_wr(8'h9F, 8'h87, "R3 clear rxf and overrun");
        frame(0, 0, 0, 0, 0, 0, 8'h97, 1'b0, "R9 framing error");
        frame(1, 1, 0, 1, 0, 0, 8'h9F, 1'b0, "R10 even parity mismatch");
        frame(1, 1, 1, 1, 0, 0, 8'hDD, 1'b1, "R10 R7 odd parity match");
        do_rd(8'hDD, "R4 read arms");
        do_wr(8'hFF, 8'hDD, "R4 write consumes arm");
        do_wr(8'h00, 8'hDC, "R4 no clear after arm consumed");
        do_rd(8'hDC, "R11 read arms");
        tx_load = 1;
        do_wr(8'h7F, 8'hDD, "R11 set beats clear");
        do_rd(8'hDD, "R4 read with overrun at 0");
        frame(1, 0, 0, 0, 0, 0, 8'hFD, 1'b0, "R8 overrun after read");
        do_wr(8'hDF, 8'hFD, "R4 unarmed overrun not cleared");
        standby = 1; tick(8'h84, 1'b0, "R2 standby");
        standby = 0; tick(8'h84, 1'b0, "R2 after standby");
        #1;
      end
      begin
        repeat (2000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: timeout, expected completion");
      end
    join_any
    wait (exp_q.size() == 0);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule